// File: doc/BRIEF.md
# Receive FIFO Status and Error Flags

This block is a small receive queue with its status register attached. A producer pushes words one per cycle and announces bursts ahead of time with a length, so the queue can refuse a burst that would not fit. A consumer pops words from the head. Software can load either pointer directly, read a 32-bit status word, and clear error flags by writing ones to them.

Two kinds of flag appear in the status word. Sticky error flags are set by hardware and cleared only by software or by a queue clear:
- illegal pointer
- receive wait (a burst was refused)
- underflow
- overflow

Live level flags follow the queue state on every cycle: full, alarm (free space at or below a threshold) and empty. A single error output combines the illegal pointer flag and the receive wait flag, each gated by its own mask input.

Pointers carry one wrap bit above the index, so a pointer value is legal when it is below twice the depth. A push into a full queue and a pop from an empty queue are dropped and only raise their flag.

Top module: `rx_fifo_stat`

## Requirements
- R1: After reset the status word reads 0x0001_0000 (only empty, bit 16, set) and `err` is 0.
- R2: Words leave in the order they were pushed. Bit 16 (empty) is 1 exactly when the queue holds no words. Bit 18 (full) is 1 exactly when it holds DEPTH words.
- R3: Bit 17 (alarm) is 1 exactly while the free space (DEPTH minus the held words) is less than or equal to `alarm_lvl`.
- R4: A push while full sets sticky bit 20 (overflow) and the word is discarded.
- R5: A pop while empty sets sticky bit 21 (underflow) and the queue is unchanged.
- R6: An `rx_req` whose `rx_len` exceeds the free space sets sticky bit 22 (receive wait). A length equal to the free space does not set it.
- R7: A software pointer write of a value of 2*DEPTH or more sets sticky bit 31 (illegal pointer) and leaves the pointer unchanged. A legal value loads the pointer.
- R8: A status write with `stat_sel` and `stat_we` high clears each sticky bit (31, 22, 21, 20) whose data bit is 1. Data bits of 0, and ones written to level or reserved bits, have no effect.
- R9: When a hardware set and a software clear of the same sticky bit fall in one cycle, the bit ends at 1.
- R10: `err` is (bit 31 AND NOT `ip_mask`) OR (bit 22 AND NOT `rxw_mask`). Underflow and overflow do not drive it.
- R11: A `fifo_clr` pulse empties the queue and clears all sticky bits.
- R12: Bits 30, 29 to 23, 19 and 15 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous queue clear |
| push | input | 1 | Write one word |
| push_data | input | DW | Word to write |
| pop | input | 1 | Remove head word |
| pop_data | output | DW | Head word |
| rx_req | input | 1 | Burst announcement |
| rx_len | input | AW+1 | Burst length in words |
| sw_rptr_we | input | 1 | Software load of read pointer |
| sw_wptr_we | input | 1 | Software load of write pointer |
| sw_ptr_val | input | PW | Pointer value to load |
| alarm_lvl | input | AW+1 | Free-space alarm threshold |
| ip_mask | input | 1 | Mask for illegal pointer error |
| rxw_mask | input | 1 | Mask for receive wait error |
| stat_sel | input | 1 | Status register select |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 32 | Status write data (ones clear) |
| stat_rdata | output | 32 | Status word |
| err | output | 1 | Masked error output |

## Verification
A corrupted pointer shows on the first later status read: empty, full or alarm reads wrong. It also shows on the next pop, because the head word breaks the pushed order. A sticky flag that fails to set, or fails to hold, shows in the status word and, for the two flags that feed `err`, on the error pin one cycle after the event. A write-one-to-clear path that clears too much or too little shows on the read that follows the write.

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  input  logic          rx_req,
  input  logic [AW:0]   rx_len,
  input  logic          sw_rptr_we,
  input  logic          sw_wptr_we,
  input  logic [PW-1:0] sw_ptr_val,
  input  logic [AW:0]   alarm_lvl,
  input  logic          ip_mask,
  input  logic          rxw_mask,
  input  logic          stat_sel,
  input  logic          stat_we,
  input  logic [31:0]   stat_wdata,
  output logic [31:0]   stat_rdata,
  output logic          err
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] rptr, wptr;
  logic ip_f, rxw_f, uf_f, of_f;

  wire [AW:0] count = wptr - rptr;
  wire [AW:0] space = DEPTH_V - count;
  wire full  = (count == DEPTH_V);
  wire empty = (count == '0);
  wire alarm = (space <= alarm_lvl);

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;
  wire ptr_ok  = (sw_ptr_val >> (AW+1)) == '0;
  wire clr_en  = stat_sel && stat_we;

  wire set_ip  = (sw_rptr_we || sw_wptr_we) && !ptr_ok;
  wire set_rxw = rx_req && (rx_len > space);
  wire set_uf  = pop && empty;
  wire set_of  = push && full;

  assign pop_data = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push && !sw_wptr_we && !fifo_clr) mem[wptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
    end else if (fifo_clr) begin
      rptr <= '0;
      wptr <= '0;
    end else begin
      if (sw_wptr_we) begin
        if (ptr_ok) wptr <= sw_ptr_val[AW:0];
      end else if (do_push) begin
        wptr <= wptr + 1'b1;
      end
      if (sw_rptr_we) begin
        if (ptr_ok) rptr <= sw_ptr_val[AW:0];
      end else if (do_pop) begin
        rptr <= rptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ip_f, rxw_f, uf_f, of_f} <= '0;
    end else if (fifo_clr) begin
      {ip_f, rxw_f, uf_f, of_f} <= '0;
    end else begin
      ip_f  <= (ip_f  && !(clr_en && stat_wdata[31])) || set_ip;
      rxw_f <= (rxw_f && !(clr_en && stat_wdata[22])) || set_rxw;
      uf_f  <= (uf_f  && !(clr_en && stat_wdata[21])) || set_uf;
      of_f  <= (of_f  && !(clr_en && stat_wdata[20])) || set_of;
    end
  end

  assign stat_rdata = {ip_f, 1'b0, 6'b0, 1'b0, rxw_f, uf_f, of_f,
                       1'b0, full, alarm, empty, 16'b0};
  assign err = (ip_f && !ip_mask) || (rxw_f && !rxw_mask);
endmodule

module rx_fifo_stat_chk #(
  parameter int AW = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_clr,
  input logic        push,
  input logic        pop,
  input logic        sw_rptr_we,
  input logic        sw_wptr_we,
  input logic        stat_sel,
  input logic        stat_we,
  input logic [31:0] stat_wdata,
  input logic [31:0] stat_rdata,
  input logic        ip_mask,
  input logic        rxw_mask,
  input logic        err
);
  a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_rdata[18] && stat_rdata[16]));

  a_r4_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (push && stat_rdata[18] && !fifo_clr) |=> stat_rdata[20]);

  a_r5_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && stat_rdata[16] && !fifo_clr) |=> stat_rdata[21]);

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (push && stat_rdata[18] && stat_sel && stat_we && stat_wdata[20] && !fifo_clr)
    |=> stat_rdata[20]);

  a_r10_err_mask: assert property (@(posedge clk) disable iff (!rst_n)
    err == ((stat_rdata[31] && !ip_mask) || (stat_rdata[22] && !rxw_mask)));

  a_r11_clear_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (stat_rdata[31:20] == 12'h000 && stat_rdata[16]));

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata & 32'h7F88_FFFF) == 32'h0);
endmodule

bind rx_fifo_stat rx_fifo_stat_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .push(push), .pop(pop),
  .sw_rptr_we(sw_rptr_we), .sw_wptr_we(sw_wptr_we), .stat_sel(stat_sel),
  .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
  .ip_mask(ip_mask), .rxw_mask(rxw_mask), .err(err)
);

// File: tb/rx_fifo_stat_tb.sv
module rx_fifo_stat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int PW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, fifo_clr = 0, push = 0, pop = 0, rx_req = 0;
  logic sw_rptr_we = 0, sw_wptr_we = 0, ip_mask = 0, rxw_mask = 0;
  logic stat_sel = 0, stat_we = 0;
  logic [DW-1:0] push_data = '0, pop_data;
  logic [AW:0] rx_len = '0, alarm_lvl = 5'd2;
  logic [PW-1:0] sw_ptr_val = '0;
  logic [31:0] stat_wdata = '0, stat_rdata;
  logic err;

  int checks = 0, errors = 0;
  logic [DW-1:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_stat #(.DW(DW), .AW(AW), .PW(PW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic drv_push(input logic [DW-1:0] d, input bit expect_keep);
    push = 1; push_data = d;
    if (expect_keep) sb_q.push_back(d);
    tick();
    push = 0;
  endtask

  task automatic mon_pop(input string req);
    logic [DW-1:0] exp;
    exp = sb_q.pop_front();
    chk(req, pop_data, exp);
    pop = 1;
    tick();
    pop = 0;
  endtask

  task automatic wr_stat(input logic [31:0] d);
    stat_sel = 1; stat_we = 1; stat_wdata = d;
    tick();
    stat_sel = 0; stat_we = 0; stat_wdata = '0;
  endtask

  task automatic req(input logic [AW:0] n);
    rx_req = 1; rx_len = n;
    tick();
    rx_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R1 reset status", stat_rdata, 32'h0001_0000);
    chk("R1 reset err", {31'b0, err}, 32'h0);

    pop = 1; tick(); pop = 0;
    chk("R5 underflow", stat_rdata, 32'h0021_0000);
    chk("R10 uf no err", {31'b0, err}, 32'h0);

    wr_stat(32'h0000_0000);
    chk("R8 zero write", stat_rdata, 32'h0021_0000);
    wr_stat(32'h7FDF_FFFF);
    chk("R8 other bits", stat_rdata, 32'h0021_0000);
    wr_stat(32'h0020_0000);
    chk("R8 clear uf", stat_rdata, 32'h0001_0000);

    for (int i = 0; i < 13; i++) drv_push(32'hA000_0000 + i, 1);
    chk("R3 no alarm free3", stat_rdata, 32'h0000_0000);
    drv_push(32'hA000_000D, 1);
    chk("R3 alarm free2", stat_rdata, 32'h0002_0000);
    drv_push(32'hA000_000E, 1);
    drv_push(32'hA000_000F, 1);
    chk("R2 full", stat_rdata, 32'h0006_0000);

    drv_push(32'hDEAD_BEEF, 0);
    chk("R4 overflow", stat_rdata, 32'h0016_0000);
    chk("R10 of no err", {31'b0, err}, 32'h0);

    req(5'd1);
    chk("R6 rxw", stat_rdata, 32'h0056_0000);
    chk("R10 rxw err", {31'b0, err}, 32'h1);
    rxw_mask = 1; #1;
    chk("R10 rxw masked", {31'b0, err}, 32'h0);
    rxw_mask = 0;

    for (int i = 0; i < DEPTH; i++) mon_pop("R2 R4 order");
    chk("R2 empty after drain", stat_rdata, 32'h0051_0000);

    wr_stat(32'hFFFF_FFFF);
    chk("R8 clear all", stat_rdata, 32'h0001_0000);
    req(5'd16);
    chk("R6 len equals space", stat_rdata, 32'h0001_0000);

    stat_sel = 1; stat_we = 1; stat_wdata = 32'h0040_0000;
    rx_req = 1; rx_len = 5'd17;
    tick();
    rx_req = 0; stat_sel = 0; stat_we = 0; stat_wdata = '0;
    chk("R9 set wins", stat_rdata, 32'h0041_0000);
    wr_stat(32'h0040_0000);
    chk("R8 clear rxw", stat_rdata, 32'h0001_0000);

    sw_wptr_we = 1; sw_ptr_val = 16'd32; tick(); sw_wptr_we = 0;
    chk("R7 illegal ptr", stat_rdata, 32'h8001_0000);
    chk("R10 ip err", {31'b0, err}, 32'h1);
    ip_mask = 1; #1;
    chk("R10 ip masked", {31'b0, err}, 32'h0);
    ip_mask = 0;

    sw_wptr_we = 1; sw_ptr_val = 16'd19; tick(); sw_wptr_we = 0;
    chk("R7 legal ptr load", stat_rdata, 32'h8000_0000);
    for (int i = 0; i < 3; i++) sb_q.push_back(32'hA000_0000 + i);
    for (int i = 0; i < 3; i++) mon_pop("R7 contents after load");
    chk("R7 empty again", stat_rdata, 32'h8001_0000);

    drv_push(32'h1234_5678, 0);
    drv_push(32'h9ABC_DEF0, 0);
    req(5'd15);
    chk("R11 before clear", stat_rdata, 32'hC040_0000 & 32'h8040_0000);
    fifo_clr = 1; tick(); fifo_clr = 0;
    chk("R11 after clear", stat_rdata, 32'h0001_0000);
    chk("R11 err after clear", {31'b0, err}, 32'h0);
    chk("R12 reserved", stat_rdata & 32'h7F88_FFFF, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule